// File: doc/BRIEF.md
# DMA Channel Address and Word-Count Unit

This block keeps the address and transfer-count state of one DMA channel. Software programs a start address and a word count through an 8-bit port. Each register is wider than the port, so it is written one byte at a time. A shared byte pointer picks which byte lane a CPU access touches. Every write loads the same byte into both the base copy and the working (current) copy of the selected register. Reads return the current copy.

While the channel is armed, each transfer-done pulse steps the current address by one, up or down as set by a mode input. The same pulse decrements the current word count. The transfer that finds the count already at zero is the last one. It wraps the count to all ones and drives a one-clock active-low end-of-process pulse. If auto-initialization is selected, that transfer instead copies both base values back into the current registers, on the same edge that starts the pulse. Without auto-initialization the channel parks in an ended state until software writes it again. Arbitration and bus timing are outside this block.

A small three-state controller governs the channel:
- **IDLE** holds after reset or master clear. It moves to **READY** on any CPU write to the address or count register.
- **READY** applies transfer-done pulses. A terminal transfer without auto-initialization moves it to **ENDED**. A terminal transfer with auto-initialization keeps it in **READY**.
- **ENDED** ignores transfer-done pulses. It moves back to **READY** on a CPU write to either register.
- Master clear returns every state to **IDLE**.

Top module: `dmac_chan_unit`

## Requirements
- R1: Reset (rst_n low) or a master-clear cycle (mclr high) sets both copies of the address and the count to zero, puts the byte pointer on the low byte, holds eop_n high and returns the controller to IDLE. The outputs show this in the cycle after mclr.
- R2: A CPU write (cpu_wr high) with cpu_sel=0 (address) or cpu_sel=1 (count) loads cpu_wdata into the byte lane selected by the pointer, in both the base and the current copy. Lane 0 is bits 7:0 and lane 1 is bits 15:8. The other lanes are left unchanged.
- R3: After each read or write access with cpu_sel 0 or 1, the byte pointer advances to the next lane and wraps after the last lane. A write with cpu_sel=2 returns the pointer to lane 0.
- R4: cpu_rdata shows the byte of the current copy selected by cpu_sel and the pointer, combinationally. A read does not change any register contents.
- R5: cpu_sel=2 or cpu_sel=3 reads return zero and do not move the pointer.
- R6: In READY, a transfer-done pulse with a nonzero count lowers cur_count by one in the next cycle.
- R7: In READY, each transfer-done pulse moves cur_addr one step in the next cycle, modulo 2^ADDR_W. The step is +1 when mode_dec is 0 and -1 when mode_dec is 1.
- R8: A transfer-done pulse in READY with cur_count equal to zero drives eop_n low for exactly one cycle, starting in the next cycle. Without auto-initialization, the count becomes all ones.
- R9: When mode_autoinit is 1, the terminal transfer loads the base address and base count into the current registers on the same edge that lowers eop_n. The channel stays in READY.
- R10: When mode_autoinit is 0, the terminal transfer moves the channel to ENDED. There, transfer-done pulses change neither cur_addr nor cur_count and raise no eop_n pulse until the next CPU write to the address or count register.
- R11: In IDLE, transfer-done pulses are ignored.
- R12: A transfer-done pulse in the same cycle as a CPU write to the address or count register is dropped. The write still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mclr | input | 1 | Synchronous master clear |
| cpu_wr | input | 1 | CPU write strobe, one byte per cycle |
| cpu_rd | input | 1 | CPU read strobe, one byte per cycle |
| cpu_sel | input | 2 | 0 address, 1 count, 2 pointer clear, 3 none |
| cpu_wdata | input | 8 | CPU write byte |
| cpu_rdata | output | 8 | CPU read byte from the current copy |
| xfer_done | input | 1 | One-cycle pulse per transferred word |
| mode_dec | input | 1 | 0 increments the address, 1 decrements it |
| mode_autoinit | input | 1 | 1 reloads the current registers at terminal count |
| cur_addr | output | ADDR_W | Current address |
| cur_count | output | CNT_W | Current word count |
| eop_n | output | 1 | Active-low terminal-count pulse |

## Verification
The bench sweeps small programmed counts across both address directions and both reload settings. It sends one extra transfer past the end of each run and predicts every address and count arithmetically. This exposes a terminal count raised on reaching zero rather than on wrapping from zero, which would pulse one transfer early. It also catches a reload one edge late, which would briefly show the wrapped count, and a missing reload, which would leave the count at all ones. Address wrap at both ends of the range catches a step of the wrong width. Extra pulses after the ended state catch a channel that keeps counting. Partial single-byte writes catch a pointer that fails to toggle or that moves on reads of unused selects. A done pulse colliding with a CPU write catches a design that lets the step corrupt the freshly loaded value.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        SEL_ADDR   = 2'd0,
        SEL_COUNT  = 2'd1,
        SEL_PTRCLR = 2'd2,
        SEL_NONE   = 2'd3
    } sel_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READY = 2'd1,
        ST_ENDED = 2'd2
    } chan_st_e;
endpackage

// File: rtl/dmac_byte_ptr.sv
module dmac_byte_ptr #(
    parameter int NBYTES = 2,
    localparam int PW = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          step,
    output logic [PW-1:0] ptr
);
    localparam logic [PW-1:0] LAST = PW'(NBYTES - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (clear) begin
            ptr <= '0;
        end else if (step) begin
            ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
        end
    end
endmodule

// File: rtl/dmac_word_reg.sv
module dmac_word_reg #(
    parameter int W  = 16,
    parameter int PW = 1,
    localparam int NB = W / dmac_pkg::BYTE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          wr_en,
    input  logic [PW-1:0] wr_lane,
    input  logic [7:0]    wr_byte,
    input  logic          reload,
    input  logic          step_en,
    input  logic          step_down,
    output logic [W-1:0]  cur
);
    logic [W-1:0]  base_q;
    logic [W-1:0]  base_n;
    logic [W-1:0]  cur_n;
    logic [NB-1:0] lane_hit;

    // one comparator per byte lane
    for (genvar i = 0; i < NB; i++) begin : g_lane
        assign lane_hit[i] = wr_en && (wr_lane == PW'(i));
    end

    always_comb begin
        base_n = base_q;
        cur_n  = cur;
        for (int i = 0; i < NB; i++) begin
            if (lane_hit[i]) begin
                base_n[i*8 +: 8] = wr_byte;
                cur_n[i*8 +: 8]  = wr_byte;
            end
        end
        if (!wr_en) begin
            if (reload) begin
                cur_n = base_q;
            end else if (step_en) begin
                cur_n = step_down ? cur - 1'b1 : cur + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            cur    <= '0;
        end else if (clr) begin
            base_q <= '0;
            cur    <= '0;
        end else begin
            base_q <= base_n;
            cur    <= cur_n;
        end
    end
endmodule

// File: rtl/dmac_chan_fsm.sv
module dmac_chan_fsm
    import dmac_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     mclr,
    input  logic     prog,
    input  logic     done,
    input  logic     cnt_zero,
    input  logic     autoinit,
    output logic     step_en,
    output logic     reload,
    output logic     eop_n,
    output chan_st_e st
);
    chan_st_e st_n;
    logic     hit_tc;
    logic     eop_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else if (mclr) begin
            st <= ST_IDLE;
        end else begin
            st <= st_n;
        end
    end

    // next state
    always_comb begin
        st_n = st;
        unique case (st)
            ST_IDLE:  if (prog) st_n = ST_READY;
            ST_READY: if (!prog && done && cnt_zero && !autoinit) st_n = ST_ENDED;
            ST_ENDED: if (prog) st_n = ST_READY;
            default:  st_n = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        step_en = (st == ST_READY) && done && !prog;
        hit_tc  = step_en && cnt_zero;
        reload  = hit_tc && autoinit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eop_q <= 1'b0;
        end else if (mclr) begin
            eop_q <= 1'b0;
        end else begin
            eop_q <= hit_tc;
        end
    end

    assign eop_n = ~eop_q;
endmodule

// File: rtl/dmac_chan_unit.sv
module dmac_chan_unit
    import dmac_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mclr,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    input  logic [1:0]        cpu_sel,
    input  logic [7:0]        cpu_wdata,
    output logic [7:0]        cpu_rdata,
    input  logic              xfer_done,
    input  logic              mode_dec,
    input  logic              mode_autoinit,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [CNT_W-1:0]  cur_count,
    output logic              eop_n
);
    localparam int NBYTES = ((ADDR_W > CNT_W) ? ADDR_W : CNT_W) / BYTE_W;
    localparam int PW     = (NBYTES > 1) ? $clog2(NBYTES) : 1;

    sel_e              sel;
    logic              sel_addr;
    logic              sel_cnt;
    logic              prog;
    logic              ptr_clr;
    logic              ptr_step;
    logic [PW-1:0]     byte_ptr;
    logic              step_en;
    logic              reload;
    chan_st_e          chan_st;
    logic [ADDR_W-1:0] addr_sh;
    logic [CNT_W-1:0]  cnt_sh;

    assign sel      = sel_e'(cpu_sel);
    assign sel_addr = (sel == SEL_ADDR);
    assign sel_cnt  = (sel == SEL_COUNT);
    assign prog     = cpu_wr && (sel_addr || sel_cnt);
    assign ptr_clr  = mclr || (cpu_wr && (sel == SEL_PTRCLR));
    assign ptr_step = (cpu_wr || cpu_rd) && (sel_addr || sel_cnt);

    dmac_byte_ptr #(.NBYTES(NBYTES)) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (ptr_clr),
        .step  (ptr_step),
        .ptr   (byte_ptr)
    );

    dmac_chan_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .mclr     (mclr),
        .prog     (prog),
        .done     (xfer_done),
        .cnt_zero (cur_count == '0),
        .autoinit (mode_autoinit),
        .step_en  (step_en),
        .reload   (reload),
        .eop_n    (eop_n),
        .st       (chan_st)
    );

    dmac_word_reg #(.W(ADDR_W), .PW(PW)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (mclr),
        .wr_en     (cpu_wr && sel_addr),
        .wr_lane   (byte_ptr),
        .wr_byte   (cpu_wdata),
        .reload    (reload),
        .step_en   (step_en),
        .step_down (mode_dec),
        .cur       (cur_addr)
    );

    dmac_word_reg #(.W(CNT_W), .PW(PW)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (mclr),
        .wr_en     (cpu_wr && sel_cnt),
        .wr_lane   (byte_ptr),
        .wr_byte   (cpu_wdata),
        .reload    (reload),
        .step_en   (step_en),
        .step_down (1'b1),
        .cur       (cur_count)
    );

    assign addr_sh = cur_addr >> {byte_ptr, 3'b000};
    assign cnt_sh  = cur_count >> {byte_ptr, 3'b000};

    always_comb begin
        if (sel_addr)     cpu_rdata = addr_sh[7:0];
        else if (sel_cnt) cpu_rdata = cnt_sh[7:0];
        else              cpu_rdata = 8'h00;
    end
endmodule

// File: rtl/dmac_chan_unit_chk.sv
module dmac_chan_unit_chk
    import dmac_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter int PW     = 1,
    parameter int NBYTES = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mclr,
    input logic              cpu_wr,
    input logic              cpu_rd,
    input logic [1:0]        cpu_sel,
    input logic              xfer_done,
    input logic [ADDR_W-1:0] cur_addr,
    input logic [CNT_W-1:0]  cur_count,
    input logic              eop_n,
    input logic [PW-1:0]     byte_ptr,
    input chan_st_e          chan_st
);
    logic wr_reg;
    assign wr_reg = cpu_wr && (cpu_sel == 2'd0 || cpu_sel == 2'd1);

    // R8
    eop_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !eop_n |=> eop_n);

    // R8
    eop_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(eop_n) |-> ($past(cur_count) == '0 && $past(xfer_done)));

    // R1
    mclr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mclr |=> (cur_addr == '0 && cur_count == '0 && eop_n && chan_st == ST_IDLE));

    // R6
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_st == ST_READY && xfer_done && !wr_reg && !mclr && cur_count != '0)
        |=> cur_count == $past(cur_count) - 1'b1);

    // R10
    ended_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_st == ST_ENDED && !cpu_wr && !mclr)
        |=> ($stable(cur_count) && $stable(cur_addr) && eop_n));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_st == ST_IDLE && !cpu_wr && !mclr) |=> ($stable(cur_count) && $stable(cur_addr)));

    // R3
    ptr_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (NBYTES > 1 && (cpu_wr || cpu_rd) && !mclr && (cpu_sel == 2'd0 || cpu_sel == 2'd1))
        |=> byte_ptr != $past(byte_ptr));

    // R5
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_wr && !mclr && cpu_sel[1]) |=> $stable(byte_ptr));
endmodule

bind dmac_chan_unit dmac_chan_unit_chk #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .PW     (PW),
    .NBYTES (NBYTES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mclr      (mclr),
    .cpu_wr    (cpu_wr),
    .cpu_rd    (cpu_rd),
    .cpu_sel   (cpu_sel),
    .xfer_done (xfer_done),
    .cur_addr  (cur_addr),
    .cur_count (cur_count),
    .eop_n     (eop_n),
    .byte_ptr  (byte_ptr),
    .chan_st   (chan_st)
);

// File: tb/dmac_chan_unit_test.sv
`timescale 1ns/1ps
module dmac_chan_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mclr = 1'b0;
    logic        cpu_wr = 1'b0;
    logic        cpu_rd = 1'b0;
    logic [1:0]  cpu_sel = 2'd3;
    logic [7:0]  cpu_wdata = 8'h00;
    logic [7:0]  cpu_rdata;
    logic        xfer_done = 1'b0;
    logic        mode_dec = 1'b0;
    logic        mode_autoinit = 1'b0;
    logic [15:0] cur_addr;
    logic [15:0] cur_count;
    logic        eop_n;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    dmac_chan_unit uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .mclr          (mclr),
        .cpu_wr        (cpu_wr),
        .cpu_rd        (cpu_rd),
        .cpu_sel       (cpu_sel),
        .cpu_wdata     (cpu_wdata),
        .cpu_rdata     (cpu_rdata),
        .xfer_done     (xfer_done),
        .mode_dec      (mode_dec),
        .mode_autoinit (mode_autoinit),
        .cur_addr      (cur_addr),
        .cur_count     (cur_count),
        .eop_n         (eop_n)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cpu_write(input logic [1:0] sel, input logic [7:0] d);
        cpu_wr = 1'b1; cpu_sel = sel; cpu_wdata = d;
        @(negedge clk);
        cpu_wr = 1'b0; cpu_sel = 2'd3;
    endtask

    task automatic cpu_read(input logic [1:0] sel, output logic [7:0] d);
        cpu_rd = 1'b1; cpu_sel = sel;
        #1 d = cpu_rdata;
        @(negedge clk);
        cpu_rd = 1'b0; cpu_sel = 2'd3;
    endtask

    task automatic load16(input logic [1:0] sel, input logic [15:0] v);
        cpu_write(2'd2, 8'h00);
        cpu_write(sel, v[7:0]);
        cpu_write(sel, v[15:8]);
    endtask

    task automatic pulse_done();
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0]  rb;
        logic [15:0] a0;
        logic [15:0] ea;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 addr", cur_addr, 0);
        chk("R1 count", cur_count, 0);
        chk("R1 eop_n", eop_n, 1);

        // R11 done ignored in idle
        for (int i = 0; i < 3; i++) begin
            pulse_done();
            chk("R11 count", cur_count, 0);
            chk("R11 eop_n", eop_n, 1);
        end

        // R2 R3 R4 byte access
        load16(2'd0, 16'h1234);
        chk("R2 addr", cur_addr, 16'h1234);
        cpu_write(2'd2, 8'h00);
        cpu_read(2'd0, rb); chk("R4 low", rb, 8'h34);
        cpu_read(2'd0, rb); chk("R4 high R3", rb, 8'h12);
        cpu_read(2'd0, rb); chk("R3 wrap", rb, 8'h34);
        chk("R4 unchanged", cur_addr, 16'h1234);
        cpu_write(2'd2, 8'h00);
        cpu_write(2'd0, 8'hAB);
        chk("R2 lane0", cur_addr, 16'h12AB);
        cpu_write(2'd0, 8'hCD);
        chk("R2 lane1 R3", cur_addr, 16'hCDAB);
        // R5 unused selects
        cpu_write(2'd2, 8'h00);
        cpu_read(2'd3, rb); chk("R5 sel3 data", rb, 0);
        cpu_read(2'd2, rb); chk("R5 sel2 data", rb, 0);
        cpu_read(2'd0, rb); chk("R5 pointer held", rb, 8'hAB);

        // sweep: direction x reload x count, incl. address wrap
        for (int d = 0; d < 2; d++) begin
            for (int ai = 0; ai < 2; ai++) begin
                for (int n = 0; n < 5; n++) begin
                    mode_dec = d[0];
                    mode_autoinit = ai[0];
                    a0 = (n == 4) ? (d ? 16'h0001 : 16'hFFFE) : 16'h0100 + 16'(n * 37);
                    load16(2'd0, a0);
                    load16(2'd1, 16'(n));
                    for (int k = 1; k <= n; k++) begin
                        pulse_done();
                        ea = d ? a0 - 16'(k) : a0 + 16'(k);
                        chk("R6 count", cur_count, 16'(n - k));
                        chk("R7 addr", cur_addr, ea);
                        chk("R8 no early eop", eop_n, 1);
                    end
                    pulse_done();
                    chk("R8 eop low", eop_n, 0);
                    if (ai) begin
                        chk("R9 addr reload", cur_addr, a0);
                        chk("R9 count reload", cur_count, 16'(n));
                    end else begin
                        ea = d ? a0 - 16'(n + 1) : a0 + 16'(n + 1);
                        chk("R8 count wrap", cur_count, 16'hFFFF);
                        chk("R7 addr last", cur_addr, ea);
                    end
                    @(negedge clk);
                    chk("R8 eop one cycle", eop_n, 1);
                    if (ai) begin
                        pulse_done();
                        chk("R9 continue count", cur_count, (n == 0) ? 16'h0 : 16'(n - 1));
                        chk("R9 continue eop", eop_n, (n == 0) ? 1'b0 : 1'b1);
                        @(negedge clk);
                    end else begin
                        for (int j = 0; j < 2; j++) begin
                            pulse_done();
                            chk("R10 count held", cur_count, 16'hFFFF);
                            chk("R10 addr held", cur_addr, ea);
                            chk("R10 no eop", eop_n, 1);
                        end
                    end
                end
            end
        end

        // R12 write collides with done
        mode_dec = 1'b0; mode_autoinit = 1'b0;
        load16(2'd1, 16'd5);
        load16(2'd0, 16'h4000);
        cpu_write(2'd2, 8'h00);
        xfer_done = 1'b1;
        cpu_write(2'd0, 8'h55);
        xfer_done = 1'b0;
        chk("R12 count", cur_count, 5);
        chk("R12 addr", cur_addr, 16'h4055);

        // R1 master clear mid-run
        pulse_done();
        chk("R6 before clear", cur_count, 4);
        mclr = 1'b1;
        @(negedge clk);
        mclr = 1'b0;
        chk("R1 mclr addr", cur_addr, 0);
        chk("R1 mclr count", cur_count, 0);
        pulse_done();
        chk("R11 after mclr", cur_count, 0);
        chk("R11 eop after mclr", eop_n, 1);
        cpu_read(2'd0, rb); chk("R1 mclr pointer", rb, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule